// File: doc/BRIEF.md
# Fetch Redirect Arbiter with Epoch Tags

This block holds the fetch program counter and two single-bit epoch registers: one tracking how many redirects the execute stage has issued, one tracking the decode stage's redirects. Each cycle it picks the next fetch address from three candidates. An execute-stage misprediction takes precedence over everything else. A decode-stage redirect is next in priority. Otherwise the address from the next-address predictor is used.

When no redirect takes effect, the block presents one fetch slot downstream. The slot carries the current address, the predicted next address and both epoch bits, so that later stages can detect wrong-path work.

Every resolved control-flow message from execute is copied to a training port in the same cycle, whether or not it reports a misprediction. A decode redirect is dropped if its execute-epoch tag no longer matches the fetch copy, because such a redirect comes from a wrong-path instruction.

Top module: `fetch_redirect_arb`

## Requirements
- R1: After reset, `fetch_pc` equals parameter `RESET_PC`, and both `out_eep` and `out_dep` are 0.
- R2: In any cycle with `ex_valid` high, `train_valid` is high and `train_pc`, `train_target`, `train_taken` and `train_mispred` equal the execute inputs, regardless of `ex_mispred`.
- R3: When `ex_valid` and `ex_mispred` are both high, the next cycle has `fetch_pc` equal to `ex_target` and `out_eep` inverted. In that cycle `out_valid` is low.
- R4: While an execute misprediction is present, a pending decode redirect is not examined. `dec_ack` stays low and `out_dep` does not change.
- R5: A decode redirect is applied when `dec_valid` is high, there is no execute misprediction, and `dec_eep` equals `out_eep`. The next cycle has `fetch_pc` equal to `dec_target` and `out_dep` inverted. In that cycle `out_valid` is low.
- R6: A decode redirect whose `dec_eep` differs from `out_eep` is discarded. It changes neither epoch bit nor `fetch_pc`, and the fetch slot is emitted as if no decode message were present.
- R7: When no redirect is applied, `out_valid` is high with `out_pc = fetch_pc` and `out_ppc = pred_pc`. If `out_ready` is high, `fetch_pc` becomes `pred_pc` on the next cycle.
- R8: When `out_ready` is low and no redirect is applied, `fetch_pc` holds its value. Redirects are still applied while `out_ready` is low.
- R9: `dec_ack` is high exactly when `dec_valid` is high and no execute misprediction is present, whether the decode redirect is applied or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | AW | Next-address predictor output for `fetch_pc` |
| ex_valid | input | 1 | Execute resolution message present |
| ex_pc | input | AW | Address of the resolved instruction |
| ex_target | input | AW | Correct next address from execute |
| ex_taken | input | 1 | Resolved direction |
| ex_mispred | input | 1 | Execute found a misprediction |
| dec_valid | input | 1 | Decode redirect message present |
| dec_target | input | AW | Address decode wants to fetch next |
| dec_eep | input | 1 | Execute-epoch tag carried by the decode message |
| dec_ack | output | 1 | Decode message consumed this cycle |
| out_ready | input | 1 | Downstream queue can accept a slot |
| out_valid | output | 1 | Fetch slot offered |
| out_pc | output | AW | Address of the fetched instruction |
| out_ppc | output | AW | Predicted next address |
| out_eep | output | 1 | Fetch copy of the execute epoch |
| out_dep | output | 1 | Fetch copy of the decode epoch |
| fetch_pc | output | AW | Current fetch address (predictor lookup) |
| train_valid | output | 1 | Training message present |
| train_pc | output | AW | Training: instruction address |
| train_target | output | AW | Training: resolved next address |
| train_taken | output | 1 | Training: resolved direction |
| train_mispred | output | 1 | Training: misprediction flag |

## Verification
The assertions assume that `pred_pc` is a function of the current `fetch_pc` and that the input messages are stable for the whole cycle in which they are presented. They also assume that an unacknowledged decode message is held until it is consumed. The stimulus drives all inputs once per cycle at the falling edge and derives `pred_pc` from the bench's own model of the fetch address. After an execute misprediction that blocks it, the stimulus presents the same decode message again. Decode tags are chosen on purpose to both match and miss the current execute epoch, including stale tags issued right after an execute redirect.

// File: rtl/fetch_redirect_arb.sv
module fetch_redirect_arb #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pred_pc,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic [AW-1:0] ex_target,
  input  logic          ex_taken,
  input  logic          ex_mispred,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_target,
  input  logic          dec_eep,
  output logic          dec_ack,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_ppc,
  output logic          out_eep,
  output logic          out_dep,
  output logic [AW-1:0] fetch_pc,
  output logic          train_valid,
  output logic [AW-1:0] train_pc,
  output logic [AW-1:0] train_target,
  output logic          train_taken,
  output logic          train_mispred
);

  logic [AW-1:0] pc_q;
  logic          eep_q, dep_q;
  logic          ex_redir, dec_take;

  assign ex_redir = ex_valid & ex_mispred;
  assign dec_ack  = dec_valid & ~ex_redir;
  assign dec_take = dec_ack & (dec_eep == eep_q);

  assign out_valid = ~ex_redir & ~dec_take;
  assign out_pc    = pc_q;
  assign out_ppc   = pred_pc;
  assign out_eep   = eep_q;
  assign out_dep   = dep_q;
  assign fetch_pc  = pc_q;

  assign train_valid   = ex_valid;
  assign train_pc      = ex_pc;
  assign train_target  = ex_target;
  assign train_taken   = ex_taken;
  assign train_mispred = ex_mispred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      eep_q <= 1'b0;
      dep_q <= 1'b0;
    end else if (ex_redir) begin
      pc_q  <= ex_target;
      eep_q <= ~eep_q;
    end else if (dec_take) begin
      pc_q  <= dec_target;
      dep_q <= ~dep_q;
    end else if (out_ready) begin
      pc_q  <= pred_pc;
    end
  end

endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pred_pc,
  input logic          ex_valid,
  input logic [AW-1:0] ex_target,
  input logic          ex_mispred,
  input logic          dec_valid,
  input logic [AW-1:0] dec_target,
  input logic          dec_eep,
  input logic          dec_ack,
  input logic          out_ready,
  input logic          out_valid,
  input logic          out_eep,
  input logic          out_dep,
  input logic [AW-1:0] fetch_pc,
  input logic          train_valid,
  input logic [AW-1:0] train_target
);

  // R2
  train_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> train_valid && train_target == ex_target);

  // R3
  ex_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_mispred |=> fetch_pc == $past(ex_target) && out_eep != $past(out_eep));

  // R3
  ex_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_mispred |-> !out_valid);

  // R4
  ex_blocks_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && ex_mispred |=> out_dep == $past(out_dep));

  // R5
  dec_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(ex_valid && ex_mispred) && dec_eep == out_eep
      |=> fetch_pc == $past(dec_target) && out_dep != $past(out_dep));

  // R6
  dec_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(ex_valid && ex_mispred) && dec_eep != out_eep
      |=> $stable(out_eep) && $stable(out_dep));

  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> fetch_pc == $past(pred_pc));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(fetch_pc));

  // R9
  dec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ack |-> dec_valid && !(ex_valid && ex_mispred));

endmodule

bind fetch_redirect_arb fetch_redirect_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .ex_valid(ex_valid),
  .ex_target(ex_target), .ex_mispred(ex_mispred), .dec_valid(dec_valid),
  .dec_target(dec_target), .dec_eep(dec_eep), .dec_ack(dec_ack),
  .out_ready(out_ready), .out_valid(out_valid), .out_eep(out_eep),
  .out_dep(out_dep), .fetch_pc(fetch_pc), .train_valid(train_valid),
  .train_target(train_target)
);

// File: tb/sim_fetch_redirect_arb.sv
`timescale 1ns/1ps
module sim_fetch_redirect_arb;
  localparam int AW = 32;
  localparam logic [AW-1:0] RST_PC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] pred_pc = '0, ex_pc = '0, ex_target = '0, dec_target = '0;
  logic ex_valid = 0, ex_taken = 0, ex_mispred = 0, dec_valid = 0, dec_eep = 0, out_ready = 0;
  logic dec_ack, out_valid, out_eep, out_dep, train_valid, train_taken, train_mispred;
  logic [AW-1:0] out_pc, out_ppc, fetch_pc, train_pc, train_target;

  always #2.5 clk = ~clk;

  fetch_redirect_arb #(.AW(AW), .RESET_PC(RST_PC)) u0 (.*);

  typedef struct {
    logic ov; logic [AW-1:0] opc; logic [AW-1:0] oppc;
    logic eep; logic dep; logic ack; logic tv; logic [AW-1:0] ttgt;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [AW-1:0] m_pc;
  logic m_eep, m_dep;

  function automatic logic [AW-1:0] pred_of(logic [AW-1:0] p);
    return (p[5:2] == 4'd3) ? p + 32'h40 : p + 32'h4;
  endfunction

  task automatic check(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit exv, bit exm, logic [AW-1:0] extgt,
                      bit decv, logic [AW-1:0] dtgt, bit deep, bit rdy, string req);
    exp_t e;
    bit hit, ack, app;
    @(negedge clk);
    hit = exv & exm;
    ack = decv & ~hit;
    app = ack & (deep == m_eep);
    e.ov = ~hit & ~app; e.opc = m_pc; e.oppc = pred_of(m_pc);
    e.eep = m_eep; e.dep = m_dep; e.ack = ack; e.tv = exv; e.ttgt = extgt; e.req = req;
    pred_pc = pred_of(m_pc);
    ex_valid = exv; ex_mispred = exm; ex_target = extgt; ex_pc = m_pc - 32'h8; ex_taken = exm;
    dec_valid = decv; dec_target = dtgt; dec_eep = deep; out_ready = rdy;
    q.push_back(e);
    if (hit) begin m_pc = extgt; m_eep = ~m_eep; end
    else if (app) begin m_pc = dtgt; m_dep = ~m_dep; end
    else if (rdy) m_pc = pred_of(m_pc);
  endtask

  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid == e.ov, e.req, "out_valid", AW'(out_valid), AW'(e.ov));
      check(dec_ack == e.ack, e.req, "dec_ack", AW'(dec_ack), AW'(e.ack));
      check(out_eep == e.eep && out_dep == e.dep, e.req, "epochs",
            AW'({out_eep, out_dep}), AW'({e.eep, e.dep}));
      check(fetch_pc == e.opc, e.req, "fetch_pc", fetch_pc, e.opc);
      if (e.ov) check(out_pc == e.opc && out_ppc == e.oppc, e.req, "out_ppc", out_ppc, e.oppc);
      check(train_valid == e.tv, e.req, "train_valid", AW'(train_valid), AW'(e.tv));
      if (e.tv) check(train_target == e.ttgt, e.req, "train_target", train_target, e.ttgt);
    end
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_pc = RST_PC; m_eep = 0; m_dep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    check(fetch_pc == RST_PC, "R1", "fetch_pc", fetch_pc, RST_PC);
    check(out_eep == 0 && out_dep == 0, "R1", "epochs", AW'({out_eep, out_dep}), '0);
    // R7 sequential fetch, includes a predicted jump
    for (int i = 0; i < 5; i++) step(0, 0, '0, 0, '0, 0, 1, "R7");
    // R8 stall holds pc
    step(0, 0, '0, 0, '0, 0, 0, "R8");
    step(0, 0, '0, 0, '0, 0, 0, "R8");
    // R2 training without misprediction, fetch continues
    step(1, 0, 32'h0000_2200, 0, '0, 0, 1, "R2");
    // R3 execute misprediction
    step(1, 1, 32'h0000_3000, 0, '0, 0, 1, "R3");
    step(0, 0, '0, 0, '0, 0, 1, "R3");
    // R6 stale decode tag (eep now 1, tag 0) discarded, fetch proceeds
    step(0, 0, '0, 1, 32'h0000_5000, 0, 1, "R6");
    step(0, 0, '0, 0, '0, 0, 1, "R6");
    // R5 matching decode tag applied
    step(0, 0, '0, 1, 32'h0000_6000, 1, 1, "R5");
    step(0, 0, '0, 0, '0, 0, 1, "R5");
    // R4 simultaneous execute and decode: execute wins, decode not acked
    step(1, 1, 32'h0000_7000, 1, 32'h0000_8000, 1, 1, "R4");
    // R9 decode message held and re-examined: now stale (eep=0), acked and discarded
    step(0, 0, '0, 1, 32'h0000_8000, 1, 1, "R9");
    // R8 redirect applied while stalled
    step(0, 0, '0, 1, 32'h0000_9000, 0, 0, "R8");
    step(0, 0, '0, 0, '0, 0, 0, "R8");
    step(1, 1, 32'h0000_A000, 0, '0, 0, 0, "R8");
    step(0, 0, '0, 0, '0, 0, 1, "R7");
    step(0, 0, '0, 0, '0, 0, 1, "R7");
    @(negedge clk);
    ex_valid = 0; dec_valid = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule